// File: doc/BRIEF.md
# Dual-Lane Read Byte Deinterleaver

This block sits behind the command decoder of a serial NOR flash interface and
handles the part of a dual I/O read that follows the command byte. The command
travels on one lane. Once the decoder recognises a dual read, it pulses `arm_i`
while chip-select is low. From then on, each qualified sample strobe presents
one bit pair on the two data pins: lane 0 carries the even bit and lane 1 the
odd bit. Four pairs make one byte, and the most significant pair comes first.

Each rebuilt byte is issued with a one-cycle valid strobe and a phase tag. The
first three bytes are tagged as address, the next byte as dummy, and every byte
after that as data until chip-select goes high. The address bytes are gathered
into a 24-bit value, with the first byte at the top. The data bytes are counted.
When chip-select rises, the block drops any partial byte and resets its phase
tracking. The address and the count keep their values until the next `arm_i`.

Top module: `dual_rd_deint`

## Requirements
- R1: After reset, `byte_vld_o` is 0, `phase_o` is 0, `addr_o` is 0 and `data_cnt_o` is 0.
- R2: A byte is sent as four pairs, most significant pair first. Pair k is sampled with bit 2k on `sio0_i` and bit 2k+1 on `sio1_i`. So the first pair gives bits 7 and 6, with bit 7 on `sio1_i`. `byte_o` presents the byte rebuilt this way.
- R3: `byte_vld_o` is high for exactly one cycle, the cycle after the clock edge that took the fourth pair of a byte. There may be any number of idle cycles between pairs.
- R4: `phase_o` tags each byte in the order of the transaction. It is 0 (address) for bytes 1 to 3, 1 (dummy) for byte 4, and 2 (data) for every later byte. The value 3 never occurs.
- R5: `addr_o` gathers the address bytes. The first address byte lands at bits 23:16 and the third at bits 7:0. `addr_o` updates in the same cycle that `byte_vld_o` presents each address byte.
- R6: `data_cnt_o` goes up by one in the same cycle that `byte_vld_o` presents each data byte. It holds its value while chip-select is high, and `arm_i` clears it to 0.
- R7: When chip-select rises, any partial byte is dropped. After the next `arm_i`, the first complete byte is assembled from fresh pairs and tagged as address.
- R8: Samples do not produce bytes while chip-select is high. They also do not produce bytes while chip-select is low but `arm_i` has not been seen since chip-select fell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select, active low, synchronous to `clk_i` |
| arm_i | input | 1 | Pulse from the command decoder: a dual read follows |
| smp_i | input | 1 | Sample strobe, one per bit pair |
| sio0_i | input | 1 | Lane 0 (even bits) |
| sio1_i | input | 1 | Lane 1 (odd bits) |
| byte_vld_o | output | 1 | Byte strobe, one cycle wide |
| byte_o | output | 8 | Rebuilt byte |
| phase_o | output | 2 | Phase tag: 0 address, 1 dummy, 2 data |
| addr_o | output | 24 | Gathered address |
| data_cnt_o | output | 16 | Data bytes in the current or last transaction |

## Verification
A pair counter that slips by one shows up on the very next `byte_vld_o`. The strobe arrives one sample early or late, and `byte_o` comes out with its pairs rotated. A byte-index error shows up as a wrong `phase_o` on the byte at the boundary. It also appears as an `addr_o` with its bytes in the wrong places once the third byte is out, and as a `data_cnt_o` off by one from the first data byte onward. A partial byte that survives chip-select shows up only after the next `arm_i`: the first address byte of that transaction is corrupted. For this reason the stimulus breaks off transactions mid-byte and then checks the following transaction.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DUMMY = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;
endpackage

// File: rtl/dl_pair_shift.sv
module dl_pair_shift #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic [LANES-1:0]  lane_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int PAIRS = BYTE_W / LANES;
  localparam int PC_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PAIRS - 1);

  logic [PC_W-1:0]         pc_q;
  logic [BYTE_W-LANES-1:0] sh_q;

  assign done_o = smp_i && !clr_i && (pc_q == PC_LAST);
  // higher lane is the odd (more significant) bit of each pair
  assign byte_o = {sh_q, lane_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      sh_q <= '0;
    end else if (clr_i) begin
      pc_q <= '0;
      sh_q <= '0;
    end else if (smp_i) begin
      sh_q <= byte_o[BYTE_W-LANES-1:0];
      pc_q <= done_o ? '0 : pc_q + PC_W'(1);
    end
  end

  a_r7_clr_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);
endmodule

// File: rtl/dl_phase_seq.sv
module dl_phase_seq
  import dl_pkg::*;
#(
  parameter int ADDR_BYTES  = 3,
  parameter int DUMMY_BYTES = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   step_i,
  output phase_e phase_o
);
  localparam int LAST  = ADDR_BYTES + DUMMY_BYTES;
  localparam int IDX_W = $clog2(LAST + 1);
  localparam logic [IDX_W-1:0] A_END = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] D_END = IDX_W'(LAST);

  logic [IDX_W-1:0] idx_q;

  always_comb begin
    if (idx_q < A_END)      phase_o = PH_ADDR;
    else if (idx_q < D_END) phase_o = PH_DUMMY;
    else                    phase_o = PH_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      idx_q <= '0;
    else if (clr_i)                   idx_q <= '0;
    else if (step_i && idx_q < D_END) idx_q <= idx_q + IDX_W'(1);
  end

  a_r4_phase_rising: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (phase_o >= $past(phase_o)));
  a_r4_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3);
endmodule

// File: rtl/dl_track.sv
module dl_track
  import dl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              step_i,
  input  phase_e            phase_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else if (arm_i) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else if (step_i) begin
      if (phase_i == PH_ADDR) addr_o <= {addr_o[ADDR_W-BYTE_W-1:0], byte_i};
      if (phase_i == PH_DATA) cnt_o  <= cnt_o + CNT_W'(1);
    end
  end

  a_r6_cnt_only_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !(step_i && phase_i == PH_DATA)) |=> $stable(cnt_o));
endmodule

// File: rtl/dual_rd_deint.sv
module dual_rd_deint
  import dl_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int LANES       = 2,
  parameter int ADDR_BYTES  = 3,
  parameter int DUMMY_BYTES = 1,
  parameter int CNT_W       = 16,
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              arm_i,
  input  logic              smp_i,
  input  logic              sio0_i,
  input  logic              sio1_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [1:0]        phase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  data_cnt_o
);
  logic              act_q;
  logic              clr;
  logic              smp_q;
  logic              done;
  logic [BYTE_W-1:0] byte_nx;
  phase_e            phase_cur;

  assign clr   = cs_n_i || arm_i;
  assign smp_q = smp_i && act_q && !clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= 1'b0;
    else if (cs_n_i) act_q <= 1'b0;
    else if (arm_i)  act_q <= 1'b1;
  end

  dl_pair_shift #(.BYTE_W(BYTE_W), .LANES(LANES)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .smp_i  (smp_q),
    .lane_i ({sio1_i, sio0_i}),
    .done_o (done),
    .byte_o (byte_nx)
  );

  dl_phase_seq #(.ADDR_BYTES(ADDR_BYTES), .DUMMY_BYTES(DUMMY_BYTES)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .step_i  (done),
    .phase_o (phase_cur)
  );

  dl_track #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .step_i  (done),
    .phase_i (phase_cur),
    .byte_i  (byte_nx),
    .addr_o  (addr_o),
    .cnt_o   (data_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      phase_o    <= PH_ADDR;
    end else begin
      byte_vld_o <= done;
      if (done) begin
        byte_o  <= byte_nx;
        phase_o <= phase_cur;
      end else if (clr) begin
        phase_o <= PH_ADDR;
      end
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  a_r8_quiet_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !byte_vld_o);
  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && phase_o == 2'd2) |-> (data_cnt_o == $past(data_cnt_o) + CNT_W'(1)));
  a_r6_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && !arm_i) |=> $stable(data_cnt_o));
endmodule

// File: tb/test_dual_rd_deint.sv
module test_dual_rd_deint;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, arm, smp, sio0, sio1;
  logic byte_vld;
  logic [7:0] byte_q;
  logic [1:0] phase;
  logic [23:0] addr;
  logic [15:0] cnt;

  int n_chk = 0, n_err = 0;
  bit done_f = 0;
  int exp_idx;
  logic [23:0] exp_addr;
  int exp_cnt;

  dual_rd_deint i_dual_rd_deint (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .arm_i(arm), .smp_i(smp),
    .sio0_i(sio0), .sio1_i(sio1), .byte_vld_o(byte_vld), .byte_o(byte_q),
    .phase_o(phase), .addr_o(addr), .data_cnt_o(cnt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_phase(int idx);
    if (idx < 3) return 2'd0;
    if (idx < 4) return 2'd1;
    return 2'd2;
  endfunction

  task automatic start_tr();
    @(negedge clk); cs_n = 0; arm = 1; smp = 0;
    @(negedge clk); arm = 0;
    exp_idx = 0; exp_addr = '0; exp_cnt = 0;
    chk("R6 arm clears count", 32'(cnt), 0);
  endtask

  task automatic end_tr();
    @(negedge clk); cs_n = 1; smp = 0;
    repeat (3) @(negedge clk);
    chk("R6 count holds", 32'(cnt), 32'(exp_cnt));
    chk("R8 no strobe", 32'(byte_vld), 0);
  endtask

  task automatic send_pair(logic [7:0] b, int k, int gap);
    @(negedge clk); smp = 1; sio1 = b[2*k+1]; sio0 = b[2*k];
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); smp = 0; sio0 = 1'($urandom); sio1 = 1'($urandom);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit rnd);
    for (int k = 3; k >= 0; k--) send_pair(b, k, (rnd && k > 0) ? int'($urandom_range(0, 2)) : 0);
    @(negedge clk); smp = 0;
    chk("R3 strobe after fourth pair", 32'(byte_vld), 1);
    chk("R2 byte value", 32'(byte_q), 32'(b));
    chk("R4 phase tag", 32'(phase), 32'(exp_phase(exp_idx)));
    if (exp_idx < 3) exp_addr = {exp_addr[15:0], b};
    else if (exp_idx >= 4) exp_cnt++;
    exp_idx++;
    chk("R6 count", 32'(cnt), 32'(exp_cnt));
    if (exp_idx <= 3) chk("R5 address", 32'(addr), 32'(exp_addr));
    @(negedge clk);
    chk("R3 single pulse", 32'(byte_vld), 0);
  endtask

  initial begin
    #1_500_000;
    if (!done_f) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; cs_n = 1; arm = 0; smp = 0; sio0 = 0; sio1 = 0;
    repeat (3) @(negedge clk);
    chk("R1 vld", 32'(byte_vld), 0);
    chk("R1 phase", 32'(phase), 0);
    chk("R1 addr", 32'(addr), 0);
    chk("R1 cnt", 32'(cnt), 0);
    rst_n = 1;

    // directed transaction
    start_tr();
    send_byte(8'h12, 0); send_byte(8'h34, 0); send_byte(8'h56, 0);
    chk("R5 full address", 32'(addr), 32'h123456);
    send_byte(8'hA5, 0);
    send_byte(8'h01, 0); send_byte(8'h80, 0); send_byte(8'h55, 0); send_byte(8'hAA, 0);
    end_tr();
    chk("R6 four data bytes", 32'(cnt), 4);

    // R8: samples while deselected, and selected without arm
    for (int k = 3; k >= 0; k--) send_pair(8'hFF, k, 0);
    @(negedge clk); smp = 0;
    chk("R8 deselected samples", 32'(byte_vld), 0);
    cs_n = 0;
    for (int k = 3; k >= 0; k--) send_pair(8'hC3, k, 0);
    @(negedge clk); smp = 0;
    chk("R8 unarmed samples", 32'(byte_vld), 0);
    chk("R8 count untouched", 32'(cnt), 4);
    @(negedge clk); cs_n = 1;

    // R7: partial byte dropped at chip-select rise
    start_tr();
    send_byte(8'h9C, 0);
    send_pair(8'hFF, 3, 0); send_pair(8'hFF, 2, 0);
    end_tr();
    start_tr();
    send_byte(8'h3E, 0);
    chk("R7 fresh first byte is address", 32'(phase), 0);
    send_byte(8'h71, 0); send_byte(8'h0F, 0); send_byte(8'h00, 0);
    send_byte(8'hE7, 0);
    end_tr();

    // random transactions
    for (int t = 0; t < 25; t++) begin
      int nb;
      nb = int'($urandom_range(1, 12));
      start_tr();
      for (int i = 0; i < nb; i++) send_byte(8'($urandom), 1);
      if ($urandom_range(0, 1) == 1) send_pair(8'($urandom), 3, 0);
      end_tr();
      chk("R6 random final count", 32'(cnt), 32'(exp_cnt));
    end

    done_f = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule